// File: doc/BRIEF.md
# Serial Channel Bit Clock Generator

This block produces the receive and transmit bit clocks for one synchronous serial channel. A six-bit control word picks a clocking mode. A divider word sets the rate when the clocks are made locally from the oscillator. In the external mode both bit clocks follow clock pins driven from outside. In the two local modes both bit clocks come from one baud divider that runs on the oscillator. Its factor is (N+1)·2^M, and one of the two modes adds a further ×16 stage.

Besides the two clocks, the block has three outputs. The first is an enable that says whether the transmit clock may be driven out onto the board. The second is a flag that says the selected receive clock is toggling. The third flags a configuration this block cannot produce. Channel set-up software writes both words, then waits for the clock-present flag before it finishes initialisation. Every register and counter runs on the oscillator clock. The two external pins pass through synchronisers before they are used.

Top module: `sclk_mode_gen`

## Requirements
- R1: After reset the control word is zero (external mode), the bit clocks are low, `tx_drive_en` is low, `cfg_err` is low and `clk_present` is low.
- R2: When control bits [2:0] = 0, bit 4 = 0 and bit 3 = 0 (external mode), `rx_bclk` and `tx_bclk` equal `ext_rx_clk` and `ext_tx_clk` as they were sampled two oscillator edges earlier.
- R3: When bits [2:0] = 7 and bit 4 = 1, both bit clocks have a period of k = (N+1)·2^M oscillator cycles. N is taken from divider word bits [5:0] and M from bits [11:8].
- R4: When bits [2:0] = 6 and bit 4 = 1, both bit clocks have a period of 16·k oscillator cycles.
- R5: Let E be the total exponent (M, plus 4 in the ×16 mode), and let t be the count of cycles since the divider restarted. If E ≥ 1, the clock is low for the first half of each period and high for the second half. If E = 0, the clock is high while (t mod (N+1)) < floor((N+1)/2), so N = 0 gives a constant low level.
- R6: A write to either register restarts the divider. In the cycle after the write edge, t = 0.
- R7: `tx_drive_en` is control bit 5 ANDed with a mode table. The table is true for mode 0 with bit 4 = 1, mode 2 with bit 4 = 1, mode 3, mode 6 with bit 4 = 1, and mode 7.
- R8: If bit 3 (high-speed) is set, or if the mode is none of the three produced ones, `cfg_err` is high and both bit clocks are held low.
- R9: `clk_present` goes high in the cycle after an edge of `rx_bclk`. It goes low once 1024 oscillator cycles pass with no edge.
- R10: Divider word bits [7:6] and [15:12] have no effect on the clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Local oscillator, clocks all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word; bits [7:6] are ignored |
| div_we | input | 1 | Divider word write strobe |
| div_wdata | input | 16 | Divider word: N in [5:0], M in [11:8] |
| ext_rx_clk | input | 1 | External receive clock pin |
| ext_tx_clk | input | 1 | External transmit clock pin |
| rx_bclk | output | 1 | Receive bit clock |
| tx_bclk | output | 1 | Transmit bit clock |
| tx_drive_en | output | 1 | Permission to drive the transmit clock pin |
| clk_present | output | 1 | Selected receive clock is toggling |
| cfg_err | output | 1 | Control word asks for an unsupported mode |

## Verification
The case hardest to reach is a rewrite of the divider word partway through a period. The clock must restart on a clean phase, with no shortened pulse. The stimulus writes the same word again some cycles into a 16-cycle period. The model resets its own time base on that same edge, and the stimulus samples the low half and the first high cycle of the new period. The second hard case is the loss of the clock-present flag. The stimulus stops the external pin, waits about a thousand cycles, then checks on each side of the 1024-cycle window.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  localparam int CTRL_BITS = 6;
  localparam int N_BITS    = 6;
  localparam int M_BITS    = 4;
  localparam int M_LSB     = 8;
  localparam int X16_SHIFT = 4;

  typedef struct packed {
    logic       tx_drive;
    logic       sub_b;
    logic       hs;
    logic [2:0] mode;
  } ctrl_t;

  // modes in which the transmit clock may leave the block
  function automatic logic oe_legal(logic [2:0] mode, logic sub_b);
    case (mode)
      3'd0, 3'd2, 3'd6: oe_legal = sub_b;
      3'd3, 3'd7:       oe_legal = 1'b1;
      default:          oe_legal = 1'b0;
    endcase
  endfunction

  // high-time threshold for an undivided prescale period
  function automatic logic [N_BITS:0] half_of(logic [N_BITS-1:0] n);
    half_of = ({1'b0, n} + 1'b1) >> 1;
  endfunction

endpackage

// File: rtl/sclk_cfg_regs.sv
module sclk_cfg_regs
  import sclk_pkg::*;
#(
  parameter int N_W = N_BITS,
  parameter int M_W = M_BITS,
  parameter int M_POS = M_LSB
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [7:0]  ctrl_wdata,
  input  logic        div_we,
  input  logic [15:0] div_wdata,
  output ctrl_t       cfg,
  output logic [N_W-1:0] n_val,
  output logic [M_W-1:0] m_val,
  output logic        wr_any
);

  logic unused_wbits;
  assign unused_wbits = ^{ctrl_wdata[7:6], div_wdata[15:M_POS+M_W],
                          div_wdata[M_POS-1:N_W]};

  assign wr_any = ctrl_we | div_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg   <= '0;
      n_val <= '0;
      m_val <= '0;
    end else begin
      if (ctrl_we) cfg <= ctrl_t'(ctrl_wdata[CTRL_BITS-1:0]);
      if (div_we) begin
        n_val <= div_wdata[N_W-1:0];
        m_val <= div_wdata[M_POS +: M_W];
      end
    end
  end

endmodule

// File: rtl/sclk_sync.sv
module sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sclk_baud_div.sv
module sclk_baud_div
  import sclk_pkg::*;
#(
  parameter int N_W   = N_BITS,
  parameter int M_W   = M_BITS,
  parameter int XSH   = X16_SHIFT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [N_W-1:0] n_val,
  input  logic [M_W-1:0] m_val,
  input  logic           x16,
  output logic           div_out,
  output logic           tick,
  output logic           phase0
);

  localparam int CW = (1 << M_W) - 1 + XSH;
  localparam int EW = $clog2(CW + 1);

  logic [N_W-1:0] pre;
  logic [CW-1:0]  oct;
  logic [EW-1:0]  ex;

  assign ex     = EW'(m_val) + (x16 ? EW'(XSH) : '0);
  assign tick   = (pre == n_val);
  assign phase0 = (pre == '0) && (oct == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pre <= '0;
      oct <= '0;
    end else if (tick) begin
      pre <= '0;
      oct <= oct + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  always_comb begin
    if (ex == '0) div_out = ({1'b0, pre} < half_of(n_val));
    else          div_out = oct[ex - EW'(1)];
  end

endmodule

// File: rtl/sclk_presence.sv
module sclk_presence #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  output logic src_edge,
  output logic present
);

  localparam int CNT_W = $clog2(LIMIT + 1);

  logic             src_prev;
  logic [CNT_W-1:0] idle;

  assign src_edge = src ^ src_prev;
  assign present  = (idle < CNT_W'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_prev <= 1'b0;
      idle     <= CNT_W'(LIMIT);
    end else begin
      src_prev <= src;
      if (src_edge)                    idle <= '0;
      else if (idle != CNT_W'(LIMIT))  idle <= idle + 1'b1;
    end
  end

endmodule

// File: rtl/sclk_mode_gen.sv
module sclk_mode_gen
  import sclk_pkg::*;
#(
  parameter int N_W         = N_BITS,
  parameter int M_W         = M_BITS,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_LIMIT  = 1024
) (
  input  logic        osc_clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [7:0]  ctrl_wdata,
  input  logic        div_we,
  input  logic [15:0] div_wdata,
  input  logic        ext_rx_clk,
  input  logic        ext_tx_clk,
  output logic        rx_bclk,
  output logic        tx_bclk,
  output logic        tx_drive_en,
  output logic        clk_present,
  output logic        cfg_err
);

  ctrl_t          cfg;
  logic [5:0]     cfg_bits;
  logic [N_W-1:0] n_val;
  logic [M_W-1:0] m_val;
  logic           wr_any;
  logic [1:0]     pin_raw, pin_sync;
  logic           mode_ext, mode_div, use_x16;
  logic           div_out, div_tick, div_phase0, src_edge;

  sclk_cfg_regs #(.N_W(N_W), .M_W(M_W)) u_regs (
    .clk(osc_clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .div_we(div_we), .div_wdata(div_wdata),
    .cfg(cfg), .n_val(n_val), .m_val(m_val), .wr_any(wr_any)
  );

  assign cfg_bits = cfg;
  assign pin_raw  = {ext_tx_clk, ext_rx_clk};

  for (genvar g = 0; g < 2; g++) begin : g_pin
    sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(osc_clk), .rst_n(rst_n), .d(pin_raw[g]), .q(pin_sync[g])
    );
  end

  assign mode_ext = !cfg.hs && !cfg.sub_b && (cfg.mode == 3'd0);
  assign mode_div = !cfg.hs &&  cfg.sub_b && (cfg.mode == 3'd6 || cfg.mode == 3'd7);
  assign use_x16  = (cfg.mode == 3'd6);

  sclk_baud_div #(.N_W(N_W), .M_W(M_W)) u_div (
    .clk(osc_clk), .rst_n(rst_n), .clr(wr_any),
    .n_val(n_val), .m_val(m_val), .x16(use_x16),
    .div_out(div_out), .tick(div_tick), .phase0(div_phase0)
  );

  assign rx_bclk     = mode_ext ? pin_sync[0] : (mode_div & div_out);
  assign tx_bclk     = mode_ext ? pin_sync[1] : (mode_div & div_out);
  assign cfg_err     = !(mode_ext || mode_div);
  assign tx_drive_en = cfg.tx_drive & oe_legal(cfg.mode, cfg.sub_b);

  sclk_presence #(.LIMIT(IDLE_LIMIT)) u_pres (
    .clk(osc_clk), .rst_n(rst_n), .src(rx_bclk),
    .src_edge(src_edge), .present(clk_present)
  );

endmodule

// File: rtl/sclk_mode_gen_chk.sv
module sclk_mode_gen_chk (
  input logic       osc_clk,
  input logic       rst_n,
  input logic       wr_any,
  input logic [5:0] cfg_bits,
  input logic       rx_bclk,
  input logic       tx_bclk,
  input logic       tx_drive_en,
  input logic       cfg_err,
  input logic       clk_present,
  input logic       src_edge,
  input logic       div_phase0
);

  // R6
  restart_phase_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    wr_any |=> div_phase0);

  // R8
  err_quiet_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    cfg_err |-> (!rx_bclk && !tx_bclk));

  // R7
  drive_gate_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    tx_drive_en |-> (cfg_bits[5] && cfg_bits[2:0] != 3'd1 &&
                     cfg_bits[2:0] != 3'd4 && cfg_bits[2:0] != 3'd5));

  // R9
  present_rise_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    src_edge |=> clk_present);

  // R9
  absent_hold_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (!src_edge && !clk_present) |=> !clk_present);

endmodule

bind sclk_mode_gen sclk_mode_gen_chk u_chk (
  .osc_clk(osc_clk), .rst_n(rst_n), .wr_any(wr_any), .cfg_bits(cfg_bits),
  .rx_bclk(rx_bclk), .tx_bclk(tx_bclk), .tx_drive_en(tx_drive_en),
  .cfg_err(cfg_err), .clk_present(clk_present), .src_edge(src_edge),
  .div_phase0(div_phase0)
);

// File: tb/sclk_mode_gen_test.sv
module sclk_mode_gen_test;

  logic osc_clk = 0, rst_n = 0, ctrl_we = 0, div_we = 0;
  logic ext_rx_clk = 0, ext_tx_clk = 0;
  logic [7:0]  ctrl_wdata = 0;
  logic [15:0] div_wdata = 0;
  wire rx_bclk, tx_bclk, tx_drive_en, clk_present, cfg_err;

  sclk_mode_gen uut (
    .osc_clk(osc_clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .div_we(div_we), .div_wdata(div_wdata), .ext_rx_clk(ext_rx_clk),
    .ext_tx_clk(ext_tx_clk), .rx_bclk(rx_bclk), .tx_bclk(tx_bclk),
    .tx_drive_en(tx_drive_en), .clk_present(clk_present), .cfg_err(cfg_err)
  );

  always #5 osc_clk = ~osc_clk;

  int checks = 0, errors = 0;
  bit done = 0, mdl_on = 0;

  // behavioural reference state, advanced on each rising edge
  int t_m = 0, n_m = 0, m_m = 0;
  logic [7:0] c_m = 0;
  logic rq1 = 0, rq2 = 0, tq1 = 0, tq2 = 0;

  always @(posedge osc_clk) begin
    if (!rst_n) begin
      t_m = 0; n_m = 0; m_m = 0; c_m = 0; rq1 = 0; rq2 = 0; tq1 = 0; tq2 = 0;
    end else begin
      rq2 = rq1; rq1 = ext_rx_clk;
      tq2 = tq1; tq1 = ext_tx_clk;
      if (ctrl_we) c_m = ctrl_wdata;
      if (div_we) begin
        n_m = div_wdata % 64;
        m_m = (div_wdata / 256) % 16;
      end
      if (ctrl_we || div_we) t_m = 0;
      else t_m++;
    end
  end

  function automatic logic div_ref(int t, int n, int m, bit x16);
    int e = m + (x16 ? 4 : 0);
    longint per = longint'(n + 1) * (longint'(1) << e);
    longint ph = t % per;
    if (e == 0) return ph < (n + 1) / 2;
    return ph >= per / 2;
  endfunction

  function automatic logic exp_clk(bit is_tx);
    int md = c_m % 8;
    bit sb = c_m[4];
    if (c_m[3]) return 1'b0;
    if (md == 0 && !sb) return is_tx ? tq2 : rq2;
    if (sb && md == 7) return div_ref(t_m, n_m, m_m, 1'b0);
    if (sb && md == 6) return div_ref(t_m, n_m, m_m, 1'b1);
    return 1'b0;
  endfunction

  function automatic string mode_tag();
    int md = c_m % 8;
    if (c_m[3]) return "R8";
    if (md == 0 && !c_m[4]) return "R2";
    if (c_m[4] && md == 7) return "R3";
    if (c_m[4] && md == 6) return "R4";
    return "R8";
  endfunction

  function automatic logic exp_oe(logic [7:0] c);
    int md = c % 8;
    bit ok = (md == 3) || (md == 7) || (c[4] && (md == 0 || md == 2 || md == 6));
    return c[5] && ok;
  endfunction

  function automatic logic exp_err(logic [7:0] c);
    int md = c % 8;
    if (c[3]) return 1'b1;
    return !((md == 0 && !c[4]) || (c[4] && (md == 6 || md == 7)));
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge osc_clk) begin
    if (mdl_on && !done) begin
      chk(mode_tag(), rx_bclk, exp_clk(1'b0));
      chk(mode_tag(), tx_bclk, exp_clk(1'b1));
      chk("R7", tx_drive_en, exp_oe(c_m));
      chk("R8", cfg_err, exp_err(c_m));
    end
  end

  task automatic write_ctrl(logic [7:0] v);
    @(negedge osc_clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge osc_clk); ctrl_we = 0;
  endtask

  task automatic write_div(logic [15:0] v);
    @(negedge osc_clk); div_we = 1; div_wdata = v;
    @(negedge osc_clk); div_we = 0;
  endtask

  task automatic measure(string req, int exp_per);
    logic p;
    int n = 0;
    @(negedge osc_clk); p = rx_bclk;
    for (int i = 0; i < 4000; i++) begin
      @(negedge osc_clk);
      if (!p && rx_bclk) break;
      p = rx_bclk;
    end
    p = rx_bclk;
    for (int i = 0; i < 4000; i++) begin
      @(negedge osc_clk);
      n++;
      if (!p && rx_bclk) break;
      p = rx_bclk;
    end
    chk_int(req, n, exp_per);
  endtask

  task automatic run_div(bit x16, int n, int m);
    write_ctrl(x16 ? 8'h36 : 8'h37);
    write_div(16'((m << 8) | n));
    measure(x16 ? "R4" : "R3", (n + 1) * (1 << (m + (x16 ? 4 : 0))));
    measure(x16 ? "R4" : "R3", (n + 1) * (1 << (m + (x16 ? 4 : 0))));
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge osc_clk);
    rst_n = 1;
    @(negedge osc_clk);
    mdl_on = 1;
    // R1 reset state
    chk("R1", rx_bclk, 1'b0);
    chk("R1", tx_bclk, 1'b0);
    chk("R1", tx_drive_en, 1'b0);
    chk("R1", cfg_err, 1'b0);
    chk("R1", clk_present, 1'b0);

    // R2 external mode, independent pin patterns
    for (int i = 0; i < 60; i++) begin
      @(negedge osc_clk);
      if (i % 3 == 0) ext_rx_clk = ~ext_rx_clk;
      if (i % 5 == 0) ext_tx_clk = ~ext_tx_clk;
    end
    repeat (3) @(negedge osc_clk);
    chk("R9", clk_present, 1'b1);
    repeat (1000) @(negedge osc_clk);
    chk("R9", clk_present, 1'b1);
    repeat (40) @(negedge osc_clk);
    chk("R9", clk_present, 1'b0);

    // R3 / R4 periods
    run_div(1'b0, 3, 0);
    run_div(1'b0, 2, 1);
    run_div(1'b0, 0, 2);
    run_div(1'b0, 1, 3);
    run_div(1'b0, 4, 0);
    run_div(1'b1, 0, 0);
    run_div(1'b1, 2, 1);
    chk("R9", clk_present, 1'b1);

    // R5 uneven duty with E = 0, N = 4: high for t mod 5 < 2
    write_ctrl(8'h37);
    write_div(16'h0004);
    chk("R5", rx_bclk, 1'b1);
    @(negedge osc_clk); chk("R5", rx_bclk, 1'b1);
    @(negedge osc_clk); chk("R5", rx_bclk, 1'b0);

    // R6 rewrite partway through a 16-cycle period
    write_div(16'h0203);
    repeat (5) @(negedge osc_clk);
    write_div(16'h0203);
    repeat (7) @(negedge osc_clk);
    chk("R6", rx_bclk, 1'b0);
    @(negedge osc_clk);
    chk("R6", rx_bclk, 1'b1);

    // R10 ignored divider bits: N = 1, M = 0 gives period 2
    write_div(16'hF0C1);
    measure("R10", 2);

    // R7 / R8 sweep of every mode and sub-mode
    for (int md = 0; md < 8; md++) begin
      for (int sb = 0; sb < 2; sb++) begin
        logic [7:0] v = 8'(32 + sb * 16 + md);
        write_ctrl(v);
        chk("R7", tx_drive_en, exp_oe(v));
        chk("R8", cfg_err, exp_err(v));
        write_ctrl(v & 8'hDF);
        chk("R7", tx_drive_en, 1'b0);
      end
    end

    // R8 high-speed select on an otherwise supported mode
    write_ctrl(8'h1F);
    repeat (4) @(negedge osc_clk);
    chk("R8", cfg_err, 1'b1);
    chk("R8", rx_bclk, 1'b0);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge osc_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

endmodule